// File: doc/BRIEF.md
# Asynchronous Envelope Capture and Slot Alignment

This front end accepts a packet-envelope pulse that arrives with no fixed phase relation to the local clock. The pulse may be shorter than one clock period. A rising edge of the envelope sets a capture flop. The capture flop is cleared from the clock domain only after the synchronised copy has been seen. A chain of flip-flops brings the captured value into the clock domain. An edge detector turns it into a single-cycle event.

The events are counted into a pending counter. A free-running slot counter divides time into slots of `SLOT_CYCLES` clocks and marks the first cycle of each slot. At each slot boundary, one pending event is turned into a presence flag that stays high for the whole of the next slot. An envelope that arrives while a flagged slot is running is held and emitted in a later slot of its own. It is never merged with another envelope and never dropped. The contention controller downstream reads `slot_flag` together with `slot_start`.

Top module: `env_slot_front`

## Requirements
- R1: After synchronous reset `slot_flag` is 0, and no slot is flagged until an envelope edge has arrived.
- R2: `slot_start` is high for exactly one cycle in every `SLOT_CYCLES` cycles, with a period of exactly `SLOT_CYCLES` (default 6).
- R3: `slot_flag` changes value only in a cycle where `slot_start` is high, so every flagged slot is a flag pulse of exactly `SLOT_CYCLES` cycles that is aligned to the slot grid.
- R4: Every rising edge of `env_in` produces exactly one flagged slot. This holds for pulse widths from below one clock period up to several periods, at any phase, provided successive rising edges are at least 10 clock cycles apart.
- R5: A flagged slot begins between 3 and 20 clock cycles after the envelope edge that caused it.
- R6: An envelope captured while earlier envelopes are pending or being emitted is queued. Each queued envelope gets its own later slot, and a nonzero pending count at a slot boundary always flags the following slot.
- R7: The capture flop is held clear while the clear request from the clock domain is high. An envelope that stays high longer than the clear handshake still counts only once, because capture responds to edges, not to levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| env_in | input | 1 | Asynchronous packet-envelope pulse, active high |
| slot_start | output | 1 | High in the first cycle of each slot |
| slot_flag | output | 1 | Presence flag, constant for the whole slot |

## Verification
The bench drives envelopes at random sub-nanosecond phases. Widths range from 1 ns, which is below the 4 ns clock period, up to 20 ns, plus one 40 ns pulse. A capture that looks at levels instead of edges would miss the 1 ns pulses or count the 40 ns pulse twice. A clear issued before the synchroniser has seen the flop would lose events, and the count check at the end of the run would fail. Dense stretches with edges 10 cycles apart force envelopes to queue behind flagged slots, so merged or dropped envelopes show up as a shortfall in flagged slots or as latency beyond the bound. A flag that stretches from the edge instead of from the slot grid changes in the middle of a slot and is reported by the alignment check.

// File: rtl/envslot_pkg.sv
`timescale 1ns/1ps
package envslot_pkg;
  localparam int DEF_SLOT_CYCLES = 6;
  localparam int DEF_SYNC_STAGES = 2;
  localparam int DEF_PEND_W      = 4;

  // Direction of a pending-count update in one cycle
  typedef enum logic [1:0] {
    PEND_HOLD = 2'b00,
    PEND_INC  = 2'b01,
    PEND_DEC  = 2'b10
  } pend_op_e;
endpackage

// File: rtl/env_capture.sv
`timescale 1ns/1ps
module env_capture (
  input  logic env_in,
  input  logic clr,
  output logic cap_q
);
  // Edge-set capture flop: a pulse of any width sets it, clr (async) wins
  always_ff @(posedge env_in or posedge clr) begin
    if (clr) cap_q <= 1'b0;
    else     cap_q <= 1'b1;
  end
endmodule

// File: rtl/env_sync.sv
`timescale 1ns/1ps
module env_sync #(
  parameter int STAGES = envslot_pkg::DEF_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] st;

  for (genvar i = 0; i < STAGES; i++) begin : g_st
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) st[0] <= 1'b0;
        else     st[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) st[i] <= 1'b0;
        else     st[i] <= st[i-1];
      end
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/slot_aligner.sv
`timescale 1ns/1ps
module slot_aligner #(
  parameter int SLOT_CYCLES = envslot_pkg::DEF_SLOT_CYCLES,
  parameter int PEND_W      = envslot_pkg::DEF_PEND_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt,
  output logic              slot_start,
  output logic              slot_flag,
  output logic [PEND_W-1:0] pend_o
);
  import envslot_pkg::*;

  localparam int PH_W = (SLOT_CYCLES > 2) ? $clog2(SLOT_CYCLES) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(SLOT_CYCLES - 1);

  logic [PH_W-1:0]   phase;
  logic [PEND_W-1:0] pend;
  logic              boundary;
  logic              take;
  pend_op_e          op;

  assign boundary = (phase == PH_LAST);
  assign take     = boundary && ((pend != '0) || evt);

  always_comb begin
    op = PEND_HOLD;
    if (evt && !take)      op = PEND_INC;
    else if (!evt && take) op = PEND_DEC;
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else if (boundary) phase <= '0;
    else phase <= phase + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else begin
      case (op)
        PEND_INC: pend <= pend + 1'b1;
        PEND_DEC: pend <= pend - 1'b1;
        default:  pend <= pend;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_start <= 1'b0;
      slot_flag  <= 1'b0;
    end else begin
      slot_start <= boundary;
      if (boundary) slot_flag <= take;
    end
  end

  assign pend_o = pend;
endmodule

// File: rtl/env_slot_front.sv
`timescale 1ns/1ps
module env_slot_front #(
  parameter int SLOT_CYCLES = envslot_pkg::DEF_SLOT_CYCLES,
  parameter int SYNC_STAGES = envslot_pkg::DEF_SYNC_STAGES,
  parameter int PEND_W      = envslot_pkg::DEF_PEND_W
) (
  input  logic clk,
  input  logic rst,
  input  logic env_in,
  output logic slot_start,
  output logic slot_flag
);
  logic              cap_q;
  logic              clr_q;
  logic              sync_q;
  logic              sync_d;
  logic              evt;
  logic [PEND_W-1:0] pend;

  env_capture u_cap (
    .env_in (env_in),
    .clr    (clr_q),
    .cap_q  (cap_q)
  );

  env_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (cap_q),
    .q   (sync_q)
  );

  // Clear request follows the synchronised copy; held during reset
  always_ff @(posedge clk) begin
    if (rst) begin
      clr_q  <= 1'b1;
      sync_d <= 1'b0;
    end else begin
      clr_q  <= sync_q;
      sync_d <= sync_q;
    end
  end

  assign evt = sync_q && !sync_d;

  slot_aligner #(
    .SLOT_CYCLES (SLOT_CYCLES),
    .PEND_W      (PEND_W)
  ) u_slot (
    .clk        (clk),
    .rst        (rst),
    .evt        (evt),
    .slot_start (slot_start),
    .slot_flag  (slot_flag),
    .pend_o     (pend)
  );
endmodule

// File: rtl/env_slot_front_chk.sv
`timescale 1ns/1ps
module env_slot_front_chk #(
  parameter int SLOT_CYCLES = 6,
  parameter int PEND_W      = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              slot_start,
  input logic              slot_flag,
  input logic              cap_q,
  input logic              clr_q,
  input logic [PEND_W-1:0] pend
);
  logic [15:0] gap;
  logic        seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (slot_start) begin
      gap  <= '0;
      seen <= 1'b1;
    end else begin
      gap <= gap + 1'b1;
    end
  end

  AST_START_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (slot_start && seen) |-> (gap == 16'(SLOT_CYCLES - 1))); // R2
  AST_FLAG_STABLE: assert property (@(posedge clk) disable iff (rst)
    !slot_start |-> $stable(slot_flag)); // R3
  AST_PEND_SERVED: assert property (@(posedge clk) disable iff (rst)
    (slot_start && $past(pend != '0)) |-> slot_flag); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    pend != '1); // R6
  AST_LATCH_CLEARED: assert property (@(posedge clk) disable iff (rst)
    clr_q |-> !cap_q); // R7
endmodule

bind env_slot_front env_slot_front_chk #(
  .SLOT_CYCLES (SLOT_CYCLES),
  .PEND_W      (PEND_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .slot_start (slot_start),
  .slot_flag  (slot_flag),
  .cap_q      (cap_q),
  .clr_q      (clr_q),
  .pend       (pend)
);

// File: tb/env_slot_front_bench.sv
`timescale 1ns/1ps
module env_slot_front_bench;
  localparam int SLOT = 6;
  localparam int LAT_MIN = 3;
  localparam int LAT_MAX = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic env_in = 1'b0;
  logic slot_start;
  logic slot_flag;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int pulses = 0;
  int flagged = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;
  int exp_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  env_slot_front u_env_slot_front (
    .clk        (clk),
    .rst        (rst),
    .env_in     (env_in),
    .slot_start (slot_start),
    .slot_flag  (slot_flag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Driver: rising edge at a random phase, then hold for width_ps
  task automatic send_pulse(input int width_ps, input int gap_cycles);
    int ph;
    @(posedge clk);
    ph = $urandom_range(0, 3999);
    #(ph * 0.001);
    env_in = 1'b1;
    exp_q.push_back(cyc);
    pulses++;
    #(width_ps * 0.001);
    env_in = 1'b0;
    repeat (gap_cycles) @(posedge clk);
  endtask

  // Monitor, sampled on the falling edge
  int last_start = -1;
  logic prev_flag = 1'b0;
  always @(negedge clk) begin
    if (mon_on) begin
      if (slot_flag !== prev_flag && !slot_start)
        check(1'b0, "R3 flag changed mid-slot", int'(slot_flag), int'(prev_flag));
      if (slot_start) begin
        if (last_start >= 0)
          check(cyc - last_start == SLOT, "R2 slot period", cyc - last_start, SLOT);
        last_start = cyc;
        if (slot_flag === 1'b1) begin
          flagged++;
          if (exp_q.size() == 0) begin
            check(1'b0, "R4 flagged slot with no envelope", flagged, pulses);
          end else begin
            int t0;
            t0 = exp_q.pop_front();
            check(cyc - t0 >= LAT_MIN && cyc - t0 <= LAT_MAX,
                  "R5 latency", cyc - t0, LAT_MAX);
          end
        end
      end
      prev_flag = slot_flag;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(slot_flag === 1'b0, "R1 flag after reset", int'(slot_flag), 0);
    mon_on = 1'b1;
    repeat (40) @(negedge clk);
    check(flagged == 0, "R1 no flagged slot while idle", flagged, 0);
    check(slot_flag === 1'b0, "R1 flag idle", int'(slot_flag), 0);

    // R4: sub-period pulses, sparse
    for (int i = 0; i < 10; i++) send_pulse($urandom_range(1000, 3500), 15);
    // R4: 1..20 ns widths, random phase
    for (int i = 0; i < 40; i++) send_pulse($urandom_range(1000, 20000), 12);
    // R7: long pulse must count once
    send_pulse(40000, 20);
    repeat (30) @(posedge clk);
    check(flagged == pulses, "R7 long pulse counted once", flagged, pulses);
    // R6: dense stream, edges 10 cycles apart, queues behind flagged slots
    for (int i = 0; i < 60; i++) send_pulse($urandom_range(1000, 8000), 9);

    repeat (60) @(posedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, "R6 no envelope left unserved", exp_q.size(), 0);
    check(flagged == pulses, "R4 one flagged slot per envelope", flagged, pulses);
    check(slot_flag === 1'b0, "R1 flag returns low when idle", int'(slot_flag), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule